// File: doc/BRIEF.md
# Pointer Tag Check Unit

This unit sits beside the load/store path and decides, for each memory access, whether the small key carried in the unused top bits of a 64-bit pointer matches the lock value stored for the memory granule being touched. The lock values live in a small internal tag store that the allocator fills through a one-entry-per-cycle write port. A check only takes place on pages that translation marks as tag-enabled and only while a global check mode is active. Otherwise the access passes untouched.

A mismatch is reported in one of two ways. A synchronous report is a fault flag returned with the access response. An asynchronous report sets a sticky flag that software reads and clears later. The mode selects synchronous, asynchronous, or a split mode in which stores report synchronously and loads asynchronously. Build parameters set the granule size: 16-byte granules take the key from bits [59:56], and 64-byte granules take it from bits [63:60]. A further parameter chooses whether synchronous faults appear with the response or one cycle after it. The unit also returns the access address with its top byte cleared, which is the form used for translation.

Top module: `tagchk_unit`

## Requirements
- R1: Each access presented with `acc_valid_i` high produces `rsp_valid_o` high in the following cycle for exactly one cycle. `rsp_fault_o` and any update of `async_flag_o` caused by that access appear in that same cycle.
- R2: With the default 16-byte granule, the key is address bits [59:56], and bits [63:60] have no effect on the check. `rsp_addr_o` returns the access address with bits [63:56] forced to zero.
- R3: The mode is encoded as 0 = off, 1 = synchronous, 2 = asynchronous, 3 = split. When `acc_page_en_i` is low or the mode is off, an access never faults and never sets `async_flag_o`.
- R4: In synchronous mode, a key/tag mismatch raises `rsp_fault_o` with the response, and a match leaves it low.
- R5: In asynchronous mode, a mismatch leaves `rsp_fault_o` low and sets `async_flag_o`.
- R6: `async_flag_o` stays set until a `clr_i` pulse, which clears it in the next cycle. If a new asynchronous mismatch arrives in the same cycle as the clear, the flag stays set.
- R7: In synchronous mode, `async_flag_o` is left unchanged, whether set or clear.
- R8: In split mode, a store mismatch raises `rsp_fault_o` and leaves the flag alone. A load mismatch does not fault and sets the flag.
- R9: After reset, `rsp_valid_o`, `rsp_fault_o` and `async_flag_o` are low, and every stored tag is 0.
- R10: An access that spans two granules is checked against both and fails if either mismatches. The granule index wraps modulo the tag store depth.
- R11: The access size code gives 2^code bytes, and codes 4 to 7 mean 16 bytes. The granule index is address bits [GRAN_LOG2+IDX_W-1:GRAN_LOG2].
- R12: `tw_valid_i` writes `tw_tag_i` into the granule `tw_gran_i`. Accesses presented from the next cycle onward see the new tag.
- R13: With PRECISE = 0, a synchronous fault appears on `rsp_fault_o` one cycle after the response instead of with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Check mode: 0 off, 1 synchronous, 2 asynchronous, 3 split |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | 64 | Tagged virtual address |
| acc_write_i | input | 1 | 1 for a store, 0 for a load |
| acc_size_i | input | 3 | Size code, 2^code bytes, capped at 16 |
| acc_page_en_i | input | 1 | Page-level tag check enable from translation |
| tw_valid_i | input | 1 | Tag write strobe |
| tw_gran_i | input | IDX_W | Granule index to write |
| tw_tag_i | input | 4 | Tag value to write |
| clr_i | input | 1 | Clear pulse for the sticky flag |
| rsp_valid_o | output | 1 | Response for the previous cycle's access |
| rsp_fault_o | output | 1 | Synchronous tag fault |
| rsp_addr_o | output | 64 | Access address with top byte removed |
| async_flag_o | output | 1 | Sticky asynchronous mismatch flag |

## Verification
On every cycle, the assertions check the response timing and the gating by page enable and mode. They also check that asynchronous and split-mode loads never fault, that the sticky flag holds until cleared and drops after a clear, and that synchronous mode leaves the flag untouched. Only the directed scenarios can show whether a given key actually matches a given stored tag. The same applies to granule-crossing and index wrap-around, the size-code cap, tag overwrite by the allocator port, the same-cycle set-over-clear priority and the delayed fault of the imprecise variant, because each needs a known tag store content to predict the outcome.

// File: rtl/tagchk_pkg.sv
// Shared types and helpers for the pointer tag check unit.
// Assumes accesses never exceed 16 bytes.
package tagchk_pkg;

    localparam int TAG_W = 4;

    typedef enum logic [1:0] {
        CHK_OFF   = 2'd0,
        CHK_SYNC  = 2'd1,
        CHK_ASYNC = 2'd2,
        CHK_SPLIT = 2'd3
    } chk_mode_e;

    // Byte count of an access from its size code, capped at 16.
    function automatic logic [4:0] size_bytes(input logic [2:0] code);
        logic [4:0] n;
        if (code >= 3'd4) n = 5'd16;
        else              n = 5'd1 << code;
        return n;
    endfunction

endpackage

// File: rtl/tagchk_addr_split.sv
// Splits a tagged pointer into key, granule indices of the first and last
// byte touched, and the untagged address used for translation.
// Assumes the access size never exceeds one granule, so at most two
// granules are touched.
module tagchk_addr_split #(
    parameter int GRAN_LOG2 = 4,
    parameter int IDX_W     = 6,
    parameter int KEY_LSB   = 56
) (
    input  logic [63:0]                addr_i,
    input  logic [2:0]                 size_i,
    output logic [tagchk_pkg::TAG_W-1:0] key_o,
    output logic [IDX_W-1:0]           idx_first_o,
    output logic [IDX_W-1:0]           idx_last_o,
    output logic                       spans_o,
    output logic [63:0]                xlat_o
);
    import tagchk_pkg::*;

    localparam int LOW_W = GRAN_LOG2 + IDX_W;

    logic [LOW_W-1:0] first_byte;
    logic [LOW_W-1:0] last_byte;
    logic [4:0]       nbytes;

    // Key extraction and top-byte removal.
    always_comb begin
        key_o  = addr_i[KEY_LSB +: TAG_W];
        xlat_o = {8'h00, addr_i[55:0]};
    end

    // Granule indices of the first and last byte, wrapping in the store.
    always_comb begin
        nbytes      = size_bytes(size_i);
        first_byte  = addr_i[LOW_W-1:0];
        last_byte   = first_byte + LOW_W'(nbytes) - LOW_W'(1);
        idx_first_o = first_byte[LOW_W-1:GRAN_LOG2];
        idx_last_o  = last_byte[LOW_W-1:GRAN_LOG2];
        spans_o     = (idx_first_o != idx_last_o);
    end

endmodule

// File: rtl/tagchk_tag_store.sv
// Per-granule tag store: one write port, two combinational read ports.
// A write lands at the clock edge; a same-cycle read returns the old tag.
// All tags reset to zero.
module tagchk_tag_store #(
    parameter int IDX_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic [IDX_W-1:0]             waddr_i,
    input  logic [tagchk_pkg::TAG_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]             raddr_a_i,
    input  logic [IDX_W-1:0]             raddr_b_i,
    output logic [tagchk_pkg::TAG_W-1:0] rdata_a_o,
    output logic [tagchk_pkg::TAG_W-1:0] rdata_b_o
);
    import tagchk_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tags [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Hold one granule's tag, loaded by the allocator write port.
        always_ff @(posedge clk) begin
            if (!rst_n)                               tags[g] <= '0;
            else if (we_i && (waddr_i == IDX_W'(g)))  tags[g] <= wdata_i;
        end
    end

    // Read both granules touched by the current access.
    always_comb begin
        rdata_a_o = tags[raddr_a_i];
        rdata_b_o = tags[raddr_b_i];
    end

endmodule

// File: rtl/tagchk_fault_ctl.sv
// Routes a mismatch to the synchronous fault or to the sticky flag
// according to mode and access direction, and times the response.
// Assumes mismatch_i is already gated by page enable and mode.
module tagchk_fault_ctl #(
    parameter bit PRECISE = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid_i,
    input  logic                  mismatch_i,
    input  tagchk_pkg::chk_mode_e mode_i,
    input  logic                  is_write_i,
    input  logic                  clr_i,
    output logic                  rsp_valid_o,
    output logic                  fault_o,
    output logic                  flag_o
);
    import tagchk_pkg::*;

    logic to_sync;
    logic to_async;
    logic rsp_q;
    logic sync_q;
    logic flag_q;

    // Classify the mismatch by mode and direction.
    always_comb begin
        to_sync  = (mode_i == CHK_SYNC)  || ((mode_i == CHK_SPLIT) && is_write_i);
        to_async = (mode_i == CHK_ASYNC) || ((mode_i == CHK_SPLIT) && !is_write_i);
    end

    // Register the response strobe and the synchronous fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q  <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            rsp_q  <= acc_valid_i;
            sync_q <= mismatch_i && to_sync;
        end
    end

    // Sticky flag: a new asynchronous mismatch wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (mismatch_i && to_async) flag_q <= 1'b1;
        else if (clr_i)                  flag_q <= 1'b0;
    end

    if (PRECISE) begin : g_precise
        // Fault travels with its response.
        always_comb fault_o = sync_q;
    end else begin : g_imprecise
        logic late_q;
        // Fault is reported one cycle after its response.
        always_ff @(posedge clk) begin
            if (!rst_n) late_q <= 1'b0;
            else        late_q <= sync_q;
        end
        always_comb fault_o = late_q;
    end

    // Drive the remaining outputs.
    always_comb begin
        rsp_valid_o = rsp_q;
        flag_o      = flag_q;
    end

endmodule

// File: rtl/tagchk_unit.sv
// Pointer tag check unit top. Compares the pointer key with the tags of
// every granule an access touches, on tag-enabled pages only, and reports
// mismatches synchronously or through a sticky flag.
// Assumes GRAN_LOG2 >= 4 so an access touches at most two granules.
module tagchk_unit #(
    parameter int GRAN_LOG2 = 4,
    parameter int IDX_W     = 6,
    parameter bit PRECISE   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             acc_valid_i,
    input  logic [63:0]      acc_addr_i,
    input  logic             acc_write_i,
    input  logic [2:0]       acc_size_i,
    input  logic             acc_page_en_i,
    input  logic             tw_valid_i,
    input  logic [IDX_W-1:0] tw_gran_i,
    input  logic [3:0]       tw_tag_i,
    input  logic             clr_i,
    output logic             rsp_valid_o,
    output logic             rsp_fault_o,
    output logic [63:0]      rsp_addr_o,
    output logic             async_flag_o
);
    import tagchk_pkg::*;

    localparam int KEY_LSB = (GRAN_LOG2 >= 6) ? 60 : 56;

    chk_mode_e        mode;
    logic [TAG_W-1:0] key;
    logic [IDX_W-1:0] idx_first;
    logic [IDX_W-1:0] idx_last;
    logic             spans;
    logic [63:0]      xlat;
    logic [TAG_W-1:0] tag_first;
    logic [TAG_W-1:0] tag_last;
    logic             check_en;
    logic             mismatch;
    logic [63:0]      addr_q;

    // Decode the mode input.
    always_comb mode = chk_mode_e'(mode_i);

    tagchk_addr_split #(
        .GRAN_LOG2 (GRAN_LOG2),
        .IDX_W     (IDX_W),
        .KEY_LSB   (KEY_LSB)
    ) u_split (
        .addr_i      (acc_addr_i),
        .size_i      (acc_size_i),
        .key_o       (key),
        .idx_first_o (idx_first),
        .idx_last_o  (idx_last),
        .spans_o     (spans),
        .xlat_o      (xlat)
    );

    tagchk_tag_store #(
        .IDX_W (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (tw_valid_i),
        .waddr_i   (tw_gran_i),
        .wdata_i   (tw_tag_i),
        .raddr_a_i (idx_first),
        .raddr_b_i (idx_last),
        .rdata_a_o (tag_first),
        .rdata_b_o (tag_last)
    );

    // Compare the key with every touched granule when checking is on.
    always_comb begin
        check_en = acc_valid_i && acc_page_en_i && (mode != CHK_OFF);
        mismatch = check_en &&
                   ((key != tag_first) || (spans && (key != tag_last)));
    end

    tagchk_fault_ctl #(
        .PRECISE (PRECISE)
    ) u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid_i (acc_valid_i),
        .mismatch_i  (mismatch),
        .mode_i      (mode),
        .is_write_i  (acc_write_i),
        .clr_i       (clr_i),
        .rsp_valid_o (rsp_valid_o),
        .fault_o     (rsp_fault_o),
        .flag_o      (async_flag_o)
    );

    // Capture the untagged address alongside the response.
    always_ff @(posedge clk) begin
        if (!rst_n)           addr_q <= '0;
        else if (acc_valid_i) addr_q <= xlat;
    end

    always_comb rsp_addr_o = addr_q;

endmodule

// File: rtl/tagchk_unit_chk.sv
// Cycle-level properties of the tag check unit, attached by bind.
module tagchk_unit_chk #(
    parameter bit PRECISE = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       acc_valid_i,
    input logic       acc_write_i,
    input logic       acc_page_en_i,
    input logic       clr_i,
    input logic       rsp_valid_o,
    input logic       rsp_fault_o,
    input logic       async_flag_o
);

    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i |=> rsp_valid_o);

    assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid_i |=> !rsp_valid_o);

    assert_gate_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && (!acc_page_en_i || mode_i == 2'd0) && !async_flag_o)
        |=> !async_flag_o);

    assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (async_flag_o && !clr_i) |=> async_flag_o);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !acc_valid_i) |=> !async_flag_o);

    assert_sync_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && !clr_i) |=> $stable(async_flag_o));

    if (PRECISE) begin : g_precise_props
        assert_fault_with_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_fault_o |-> rsp_valid_o);

        assert_gate_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid_i && (!acc_page_en_i || mode_i == 2'd0)) |=> !rsp_fault_o);

        assert_async_nofault_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid_i && mode_i == 2'd2) |=> !rsp_fault_o);

        assert_split_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid_i && mode_i == 2'd3 && !acc_write_i) |=> !rsp_fault_o);
    end

endmodule

bind tagchk_unit tagchk_unit_chk #(.PRECISE(PRECISE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .acc_valid_i   (acc_valid_i),
    .acc_write_i   (acc_write_i),
    .acc_page_en_i (acc_page_en_i),
    .clr_i         (clr_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_fault_o   (rsp_fault_o),
    .async_flag_o  (async_flag_o)
);

// File: tb/tagchk_unit_tb.sv
// Directed bench for the tag check unit: one task per scenario.
module tagchk_unit_tb;

    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_i = 2'd0;
    logic             acc_valid_i = 1'b0;
    logic [63:0]      acc_addr_i = '0;
    logic             acc_write_i = 1'b0;
    logic [2:0]       acc_size_i = 3'd0;
    logic             acc_page_en_i = 1'b0;
    logic             tw_valid_i = 1'b0;
    logic [IDX_W-1:0] tw_gran_i = '0;
    logic [3:0]       tw_tag_i = '0;
    logic             clr_i = 1'b0;
    logic             rsp_valid_o, rsp_fault_o, async_flag_o;
    logic [63:0]      rsp_addr_o;
    logic             imp_valid, imp_fault, imp_flag;
    logic [63:0]      imp_addr;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    tagchk_unit #(.GRAN_LOG2(4), .IDX_W(IDX_W), .PRECISE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .acc_valid_i(acc_valid_i),
        .acc_addr_i(acc_addr_i), .acc_write_i(acc_write_i), .acc_size_i(acc_size_i),
        .acc_page_en_i(acc_page_en_i), .tw_valid_i(tw_valid_i), .tw_gran_i(tw_gran_i),
        .tw_tag_i(tw_tag_i), .clr_i(clr_i), .rsp_valid_o(rsp_valid_o),
        .rsp_fault_o(rsp_fault_o), .rsp_addr_o(rsp_addr_o), .async_flag_o(async_flag_o)
    );

    tagchk_unit #(.GRAN_LOG2(4), .IDX_W(IDX_W), .PRECISE(1'b0)) u_dut_imp (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .acc_valid_i(acc_valid_i),
        .acc_addr_i(acc_addr_i), .acc_write_i(acc_write_i), .acc_size_i(acc_size_i),
        .acc_page_en_i(acc_page_en_i), .tw_valid_i(tw_valid_i), .tw_gran_i(tw_gran_i),
        .tw_tag_i(tw_tag_i), .clr_i(clr_i), .rsp_valid_o(imp_valid),
        .rsp_fault_o(imp_fault), .rsp_addr_o(imp_addr), .async_flag_o(imp_flag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Build a tagged address: top nibble, key, granule index, byte offset.
    function automatic logic [63:0] mk(input logic [3:0] top, input logic [3:0] key,
                                       input int gran, input int off);
        return {top, key, 46'h0_1234_5678_9A, 10'(gran * 16 + off)};
    endfunction

    task automatic put_tag(input int gran, input logic [3:0] t);
        @(negedge clk);
        tw_valid_i = 1'b1; tw_gran_i = IDX_W'(gran); tw_tag_i = t;
        @(negedge clk);
        tw_valid_i = 1'b0;
    endtask

    // Present one access; return with outputs of its response cycle visible.
    task automatic access(input logic [1:0] mode, input logic [63:0] addr, input logic wr,
                          input logic [2:0] sz, input logic pen, input logic clr);
        @(negedge clk);
        mode_i = mode; acc_addr_i = addr; acc_write_i = wr; acc_size_i = sz;
        acc_page_en_i = pen; clr_i = clr; acc_valid_i = 1'b1;
        @(negedge clk);
        acc_valid_i = 1'b0; clr_i = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 rsp_valid after reset", 64'(rsp_valid_o), 64'd0);
        chk("R9 fault after reset", 64'(rsp_fault_o), 64'd0);
        chk("R9 flag after reset", 64'(async_flag_o), 64'd0);
        access(2'd1, mk(4'h0, 4'h0, 20, 0), 1'b0, 3'd3, 1'b1, 1'b0);
        chk("R9 reset tag is zero", 64'(rsp_fault_o), 64'd0);
        @(negedge clk);
        chk("R1 one-cycle response", 64'(rsp_valid_o), 64'd0);
    endtask

    task automatic t_sync();
        put_tag(5, 4'h3);
        access(2'd1, mk(4'h0, 4'h3, 5, 0), 1'b0, 3'd2, 1'b1, 1'b0);
        chk("R1 rsp_valid", 64'(rsp_valid_o), 64'd1);
        chk("R4 sync match", 64'(rsp_fault_o), 64'd0);
        access(2'd1, mk(4'h0, 4'h7, 5, 4), 1'b0, 3'd2, 1'b1, 1'b0);
        chk("R4 sync load mismatch", 64'(rsp_fault_o), 64'd1);
        chk("R7 sync leaves flag clear", 64'(async_flag_o), 64'd0);
        chk("R13 imprecise not yet", 64'(imp_fault), 64'd0);
        @(negedge clk);
        chk("R13 imprecise one cycle later", 64'(imp_fault), 64'd1);
        access(2'd1, mk(4'h0, 4'h7, 5, 8), 1'b1, 3'd3, 1'b1, 1'b0);
        chk("R4 sync store mismatch", 64'(rsp_fault_o), 64'd1);
    endtask

    task automatic t_top_byte();
        logic [63:0] a;
        a = mk(4'hF, 4'h3, 5, 2);
        access(2'd1, a, 1'b0, 3'd0, 1'b1, 1'b0);
        chk("R2 bits 63:60 ignored", 64'(rsp_fault_o), 64'd0);
        chk("R2 top byte stripped", rsp_addr_o, {8'h00, a[55:0]});
        access(2'd1, mk(4'hA, 4'h2, 5, 2), 1'b0, 3'd0, 1'b1, 1'b0);
        chk("R2 key from bits 59:56", 64'(rsp_fault_o), 64'd1);
    endtask

    task automatic t_gate();
        access(2'd1, mk(4'h0, 4'h7, 5, 0), 1'b0, 3'd2, 1'b0, 1'b0);
        chk("R3 page disabled no fault", 64'(rsp_fault_o), 64'd0);
        access(2'd0, mk(4'h0, 4'h7, 5, 0), 1'b1, 3'd2, 1'b1, 1'b0);
        chk("R3 mode off no fault", 64'(rsp_fault_o), 64'd0);
        access(2'd2, mk(4'h0, 4'h7, 5, 0), 1'b0, 3'd2, 1'b0, 1'b0);
        chk("R3 page disabled no flag", 64'(async_flag_o), 64'd0);
    endtask

    task automatic t_async();
        access(2'd2, mk(4'h0, 4'h7, 5, 0), 1'b0, 3'd2, 1'b1, 1'b0);
        chk("R5 async no fault", 64'(rsp_fault_o), 64'd0);
        chk("R5 async sets flag", 64'(async_flag_o), 64'd1);
        access(2'd2, mk(4'h0, 4'h3, 5, 0), 1'b0, 3'd2, 1'b1, 1'b0);
        chk("R6 flag sticky", 64'(async_flag_o), 64'd1);
        access(2'd1, mk(4'h0, 4'h7, 5, 0), 1'b0, 3'd2, 1'b1, 1'b0);
        chk("R4 sync fault while flag set", 64'(rsp_fault_o), 64'd1);
        chk("R7 sync keeps flag set", 64'(async_flag_o), 64'd1);
        pulse_clear();
        chk("R6 clear pulse", 64'(async_flag_o), 64'd0);
        access(2'd1, mk(4'h0, 4'h7, 5, 0), 1'b0, 3'd2, 1'b1, 1'b0);
        chk("R7 sync keeps flag clear", 64'(async_flag_o), 64'd0);
        access(2'd2, mk(4'h0, 4'h7, 5, 0), 1'b0, 3'd2, 1'b1, 1'b1);
        chk("R6 set wins over clear", 64'(async_flag_o), 64'd1);
        pulse_clear();
    endtask

    task automatic t_split();
        access(2'd3, mk(4'h0, 4'h7, 5, 0), 1'b1, 3'd2, 1'b1, 1'b0);
        chk("R8 split store faults", 64'(rsp_fault_o), 64'd1);
        chk("R8 split store no flag", 64'(async_flag_o), 64'd0);
        access(2'd3, mk(4'h0, 4'h7, 5, 0), 1'b0, 3'd2, 1'b1, 1'b0);
        chk("R8 split load no fault", 64'(rsp_fault_o), 64'd0);
        chk("R8 split load sets flag", 64'(async_flag_o), 64'd1);
        pulse_clear();
    endtask

    task automatic t_cross();
        put_tag(9, 4'hA);
        put_tag(10, 4'h6);
        access(2'd1, mk(4'h0, 4'hA, 9, 12), 1'b0, 3'd3, 1'b1, 1'b0);
        chk("R10 spill into mismatching granule", 64'(rsp_fault_o), 64'd1);
        access(2'd1, mk(4'h0, 4'hA, 9, 8), 1'b0, 3'd3, 1'b1, 1'b0);
        chk("R10 fits in one granule", 64'(rsp_fault_o), 64'd0);
        put_tag(10, 4'hA);
        access(2'd1, mk(4'h0, 4'hA, 9, 12), 1'b0, 3'd3, 1'b1, 1'b0);
        chk("R10 both granules match", 64'(rsp_fault_o), 64'd0);
        put_tag(63, 4'hC);
        access(2'd1, mk(4'h0, 4'hC, 63, 15), 1'b0, 3'd1, 1'b1, 1'b0);
        chk("R10 wrap to granule 0 mismatch", 64'(rsp_fault_o), 64'd1);
        put_tag(0, 4'hC);
        access(2'd1, mk(4'h0, 4'hC, 63, 15), 1'b0, 3'd1, 1'b1, 1'b0);
        chk("R10 wrap to granule 0 match", 64'(rsp_fault_o), 64'd0);
        access(2'd1, mk(4'h0, 4'hA, 9, 0), 1'b0, 3'd7, 1'b1, 1'b0);
        chk("R11 code 7 is 16 bytes aligned", 64'(rsp_fault_o), 64'd0);
        access(2'd1, mk(4'h0, 4'h3, 5, 1), 1'b0, 3'd7, 1'b1, 1'b0);
        chk("R11 code 7 spills 16 bytes", 64'(rsp_fault_o), 64'd1);
        access(2'd1, mk(4'h0, 4'h3, 5, 15), 1'b0, 3'd0, 1'b1, 1'b0);
        chk("R11 one byte at granule end", 64'(rsp_fault_o), 64'd0);
    endtask

    task automatic t_rewrite();
        put_tag(5, 4'h9);
        access(2'd1, mk(4'h0, 4'h3, 5, 0), 1'b0, 3'd2, 1'b1, 1'b0);
        chk("R12 old key now faults", 64'(rsp_fault_o), 64'd1);
        access(2'd1, mk(4'h0, 4'h9, 5, 0), 1'b0, 3'd2, 1'b1, 1'b0);
        chk("R12 new key passes", 64'(rsp_fault_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync();
        t_top_byte();
        t_gate();
        t_async();
        t_split();
        t_cross();
        t_rewrite();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule